// File: doc/BRIEF.md
# Clock-Stop and Sleep Power State Controller

This block sequences a processor-style core through three power levels: Running, Stop-Grant and Sleep. A stop-clock request takes the core from Running into Stop-Grant. There the core clocks are switched off, while the bus and interrupt-controller units keep their clocks and keep serving snoops and interrupts. A sleep request is only honoured while in Stop-Grant. It leads one level deeper into Sleep, where every internal clock enable drops and snoops and interrupts are refused.

All three request inputs (stop-clock, sleep and reset request) are asynchronous. Each passes through its own two-flop synchronizer before the state machine sees it. Every output is registered. An input change therefore shows at the outputs on the third rising clock edge after it. On the single move from Running to Stop-Grant, the block raises a one-cycle strobe asking the bus logic to issue a Stop-Grant acknowledge transaction.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the state is Running: `core_clk_en`=1, `bus_clk_en`=1, `snoop_irq_accept`=1, `sg_ack_req`=0.
- R2: In Running, a high `stop_req_a` moves the block to Stop-Grant. `sg_ack_req` is high for exactly the one cycle in which Stop-Grant is entered from Running.
- R3: In Stop-Grant, `core_clk_en`=0 while `bus_clk_en`=1 and `snoop_irq_accept`=1. The stop request never lowers the bus-unit enable by itself.
- R4: In Stop-Grant, a high `sleep_req_a` moves to Sleep, where `core_clk_en`=0, `bus_clk_en`=0 and `snoop_irq_accept`=0.
- R5: In Running, `sleep_req_a` is ignored. With stop low, all outputs stay at their Running values.
- R6: In Sleep, a low `sleep_req_a` returns the block to Stop-Grant. `bus_clk_en` and `snoop_irq_accept` return to 1, and no acknowledge strobe is raised.
- R7: In Stop-Grant, with both stop and sleep low, the block returns to Running and `core_clk_en` returns to 1.
- R8: In Sleep, a change of `stop_req_a` alone has no effect. The block stays in Sleep while sleep is high.
- R9: A high `reset_req_a` returns the block to Running from any state, takes priority over the other requests, and raises no acknowledge strobe.
- R10: A change on any request input reaches the outputs on the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_a | input | 1 | Asynchronous stop-clock request, active high |
| sleep_req_a | input | 1 | Asynchronous sleep request, active high |
| reset_req_a | input | 1 | Asynchronous request to return to Running, active high |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus and interrupt-unit clock enable |
| snoop_irq_accept | output | 1 | High when snoops and interrupts may be serviced |
| sg_ack_req | output | 1 | One-cycle request to issue a Stop-Grant acknowledge |

## Verification
Directed sequences walk the block down Running, Stop-Grant, Sleep and back up. This separates the two levels by which enables drop and shows that the strobe fires only on the Running-to-Stop-Grant step. Further patterns raise sleep in Running and toggle stop while asleep; an output change in either would reveal a missing input mask. A reset request is applied from Sleep, and an input edge is sampled at two and at three edges to pin down the synchronizer latency. Long random runs of held request combinations are then compared cycle by cycle against a bench model of the level rules.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_GRANT = 2'd1,
    PS_SLEEP = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_a;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_s,
  input  logic       sleep_s,
  input  logic       rreq_s,
  output pwr_state_t state,
  output logic       core_en,
  output logic       bus_en,
  output logic       accept,
  output logic       ack
);
  pwr_state_t nxt;

  always_comb begin
    nxt = state;
    if (rreq_s) begin
      nxt = PS_RUN;
    end else begin
      unique case (state)
        PS_RUN:   if (stop_s) nxt = PS_GRANT;
        PS_GRANT: if (sleep_s) nxt = PS_SLEEP;
                  else if (!stop_s) nxt = PS_RUN;
        PS_SLEEP: if (!sleep_s) nxt = PS_GRANT;
        default:  nxt = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_RUN;
      core_en <= 1'b1;
      bus_en  <= 1'b1;
      accept  <= 1'b1;
      ack     <= 1'b0;
    end else begin
      state   <= nxt;
      core_en <= (nxt == PS_RUN);
      bus_en  <= (nxt != PS_SLEEP);
      accept  <= (nxt != PS_SLEEP);
      ack     <= (state == PS_RUN) && (nxt == PS_GRANT);
    end
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_req_a,
  input  logic sleep_req_a,
  input  logic reset_req_a,
  output logic core_clk_en,
  output logic bus_clk_en,
  output logic snoop_irq_accept,
  output logic sg_ack_req
);
  localparam int NREQ = 3;

  logic [NREQ-1:0] req_s;
  pwr_state_t      state;

  pwr_sync #(.STAGES(SYNC_STAGES), .W(NREQ)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_a ({reset_req_a, sleep_req_a, stop_req_a}),
    .q   (req_s)
  );

  pwr_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .stop_s  (req_s[0]),
    .sleep_s (req_s[1]),
    .rreq_s  (req_s[2]),
    .state   (state),
    .core_en (core_clk_en),
    .bus_en  (bus_clk_en),
    .accept  (snoop_irq_accept),
    .ack     (sg_ack_req)
  );
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] req_s,
  input logic       core_clk_en,
  input logic       bus_clk_en,
  input logic       snoop_irq_accept,
  input logic       sg_ack_req
);
  assert_ack_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    sg_ack_req |=> !sg_ack_req);
  assert_ack_from_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sg_ack_req) |-> ($past(core_clk_en) && !core_clk_en));
  assert_core_needs_bus_R3: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> (bus_clk_en && snoop_irq_accept));
  assert_sleep_from_grant_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_clk_en) && !$past(rst)) |-> !$past(core_clk_en));
  assert_sleep_ignored_run_R5: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && !req_s[0]) |=> core_clk_en);
  assert_stop_masked_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    (!bus_clk_en && req_s[1] && !req_s[2]) |=> !bus_clk_en);
  assert_reset_req_R9: assert property (@(posedge clk) disable iff (rst)
    req_s[2] |=> (core_clk_en && !sg_ack_req));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_s            (req_s),
  .core_clk_en      (core_clk_en),
  .bus_clk_en       (bus_clk_en),
  .snoop_irq_accept (snoop_irq_accept),
  .sg_ack_req       (sg_ack_req)
);

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int M_RUN = 0, M_GRANT = 1, M_SLEEP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop = 1'b0, slp = 1'b0, rreq = 1'b0;
  logic core_en, bus_en, accept, ack;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl uut (
    .clk (clk), .rst (rst),
    .stop_req_a (stop), .sleep_req_a (slp), .reset_req_a (rreq),
    .core_clk_en (core_en), .bus_clk_en (bus_en),
    .snoop_irq_accept (accept), .sg_ack_req (ack)
  );

  // Bench model of the level rules with two-stage input delay
  logic [2:0] m_d1 = '0, m_d2 = '0;
  int m_state = M_RUN;
  logic m_ack = 1'b0;

  function automatic int next_level(int s, logic st, logic sl, logic rr);
    if (rr) return M_RUN;
    case (s)
      M_RUN:   return st ? M_GRANT : M_RUN;
      M_GRANT: return sl ? M_SLEEP : (st ? M_GRANT : M_RUN);
      default: return sl ? M_SLEEP : M_GRANT;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_d1 <= '0; m_d2 <= '0; m_state <= M_RUN; m_ack <= 1'b0;
    end else begin
      m_d1 <= {rreq, slp, stop};
      m_d2 <= m_d1;
      m_state <= next_level(m_state, m_d2[0], m_d2[1], m_d2[2]);
      m_ack <= (m_state == M_RUN) &&
               (next_level(m_state, m_d2[0], m_d2[1], m_d2[2]) == M_GRANT);
    end
  end

  task automatic expect_out(string tag, logic e_core, logic e_bus, logic e_ack);
    logic [3:0] got, exp;
    got = {core_en, bus_en, accept, ack};
    exp = {e_core, e_bus, e_bus, e_ack};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: core/bus/accept/ack actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    cyc(3);
    expect_out("R1 in reset", 1, 1, 0);
    rst = 1'b0;
    cyc(1);
    expect_out("R1 after reset", 1, 1, 0);

    // R5: sleep in Running ignored
    slp = 1'b1;
    cyc(6);
    expect_out("R5 sleep in run", 1, 1, 0);
    slp = 1'b0;
    cyc(4);

    // R10 and R2: stop edge latency and single strobe
    stop = 1'b1;
    cyc(2);
    expect_out("R10 not before third edge", 1, 1, 0);
    cyc(1);
    expect_out("R2 grant entry strobe", 0, 1, 1);
    cyc(1);
    expect_out("R2 strobe one cycle / R3 grant", 0, 1, 0);
    cyc(5);
    expect_out("R3 grant held, bus clock kept", 0, 1, 0);

    // R4: into Sleep
    slp = 1'b1;
    cyc(3);
    expect_out("R4 sleep entry", 0, 0, 0);
    // R8: stop changes ignored in Sleep
    stop = 1'b0;
    cyc(5);
    expect_out("R8 stop low in sleep", 0, 0, 0);
    stop = 1'b1;
    cyc(5);
    expect_out("R8 stop high in sleep", 0, 0, 0);

    // R6: leave Sleep to Stop-Grant, no strobe
    slp = 1'b0;
    cyc(3);
    expect_out("R6 sleep exit", 0, 1, 0);
    cyc(2);
    expect_out("R6 no strobe", 0, 1, 0);

    // R7: back to Running
    stop = 1'b0;
    cyc(3);
    expect_out("R7 resume run", 1, 1, 0);

    // R9: reset request from Sleep, with other requests held
    stop = 1'b1;
    cyc(4);
    slp = 1'b1;
    cyc(4);
    expect_out("R4 sleep before reset req", 0, 0, 0);
    rreq = 1'b1;
    cyc(3);
    expect_out("R9 reset request from sleep", 1, 1, 0);
    cyc(3);
    expect_out("R9 reset request priority", 1, 1, 0);
    rreq = 1'b0; stop = 1'b0; slp = 1'b0;
    cyc(6);
    expect_out("R9 idle after release", 1, 1, 0);

    // Random phase against the model
    for (int it = 0; it < 3000; it++) begin
      stop = $urandom_range(0, 1);
      slp  = $urandom_range(0, 1);
      rreq = ($urandom_range(0, 15) == 0);
      for (int k = 0; k < int'($urandom_range(1, 8)); k++) begin
        cyc(1);
        case (m_state)
          M_RUN:   expect_out(m_ack ? "R2 random" : "R7 random", 1, 1, m_ack);
          M_GRANT: expect_out(m_ack ? "R2 random" : "R3 random", 0, 1, m_ack);
          default: expect_out("R4 random", 0, 0, m_ack);
        endcase
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule